// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector

This block compares the rising edges of a reference signal against the rising edges of a feedback signal. Both signals arrive on a fast system clock and are synchronised before use. The result is a three-state charge command with three conditions: drive high, drive low, or released (drive enable low). A loop filter outside the block turns that command into an oscillator control level.

A rising edge on the reference that arrives first makes the block drive high. It keeps driving high until the next rising edge on the feedback input, and then it releases. A feedback edge that arrives first makes the block drive low in the same way, until the next reference edge. Falling edges are ignored, so the duty cycle of either input has no effect. In steady lock the output stays released except for short corrections at the aligned edges. The block also has a lock flag that is high exactly while the charge output is released.

Both inputs and all outputs are plain level signals. There is no data stream and no handshake.

Top module: `tristate_pfd`

## Requirements
- R1: A synchronous active-high `rst` puts the block in the released state: `drv_en`=0, `drv_level`=0, `locked`=1, from the first clock edge that samples `rst` high.
- R2: An input level that is present at clock edge k acts on the outputs after edge k+2, which is the third edge that samples it. This holds for both inputs with the default two synchroniser stages.
- R3: If a reference rising edge is seen while the block is released and no feedback edge is seen in the same cycle, the block drives high (`drv_en`=1, `drv_level`=1). It keeps driving high until a feedback rising edge is seen, and then it releases.
- R4: If a feedback rising edge is seen while the block is released and no reference edge is seen in the same cycle, the block drives low (`drv_en`=1, `drv_level`=0). It keeps driving low until a reference rising edge is seen, and then it releases.
- R5: Further reference rising edges that arrive while the block is driving high, including one-cycle spurious pulses, keep it driving high.
- R6: With no reference edges, each feedback edge keeps the block driving low, and it never releases.
- R7: Rising edges seen on both inputs in the same cycle put the block in the released state with no drive pulse, whatever state it was in before.
- R8: `locked` is 1 exactly when `drv_en` is 0. `drv_level` is 0 whenever `drv_en` is 0.
- R9: Falling edges have no effect. Changing only the high time of either input leaves the output sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference signal, asynchronous to clk |
| fb_in | input | 1 | Feedback signal, asynchronous to clk |
| drv_en | output | 1 | Charge output is driving (0 = released) |
| drv_level | output | 1 | Driven level when drv_en is 1 |
| locked | output | 1 | High while the charge output is released |

## Verification
The bench uses square waves in three phase relations:
- reference leading, which must give only high pulses;
- feedback leading, which must give only low pulses;
- in phase, with both edges in the same cycle, which must leave the output released throughout.

Further patterns check specific behaviour:
- A run with only feedback toggling shows the detector stays driving low and never releases.
- Lone pulses measure the edge-to-output latency.
- A spurious pulse placed in the reference's low time shows that extra reference edges are absorbed while driving high.
- Patterns that differ only in duty cycle show that falling edges have no effect.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    PFD_REL = 2'b00,
    PFD_UP  = 2'b01,
    PFD_DN  = 2'b10
  } pfd_state_t;
endpackage

// File: rtl/pfd_sync_edge.sv
module pfd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[LAST-1:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[LAST];
  end

  assign rise = chain[LAST] & ~prev;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R9
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_rise,
  input  logic       fb_rise,
  output pfd_state_t state
);
  pfd_state_t nxt;

  always_comb begin
    nxt = state;
    if (ref_rise && fb_rise)
      nxt = PFD_REL;
    else if (ref_rise)
      nxt = (state == PFD_DN) ? PFD_REL : PFD_UP;
    else if (fb_rise)
      nxt = (state == PFD_UP) ? PFD_REL : PFD_DN;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PFD_REL;
    else     state <= nxt;
  end

  AST_RESET_RELEASES: assert property (@(posedge clk)
    rst |=> (state == PFD_REL)); // R1
  AST_REF_FIRST_UP: assert property (@(posedge clk) disable iff (rst)
    (state == PFD_REL && ref_rise && !fb_rise) |=> (state == PFD_UP)); // R3
  AST_FB_FIRST_DN: assert property (@(posedge clk) disable iff (rst)
    (state == PFD_REL && fb_rise && !ref_rise) |=> (state == PFD_DN)); // R4
  AST_UP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state == PFD_UP && !fb_rise) |=> (state == PFD_UP)); // R5
  AST_DN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state == PFD_DN && !ref_rise) |=> (state == PFD_DN)); // R6
  AST_BOTH_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (ref_rise && fb_rise) |=> (state == PFD_REL)); // R7
endmodule

// File: rtl/pfd_drive_decode.sv
module pfd_drive_decode
  import pfd_pkg::*;
(
  input  pfd_state_t state,
  output logic       drv_en,
  output logic       drv_level,
  output logic       locked
);
  always_comb begin
    drv_en    = 1'b0;
    drv_level = 1'b0;
    unique case (state)
      PFD_UP:  begin drv_en = 1'b1; drv_level = 1'b1; end
      PFD_DN:  begin drv_en = 1'b1; drv_level = 1'b0; end
      default: begin drv_en = 1'b0; drv_level = 1'b0; end
    endcase
    locked = (state == PFD_REL);
  end
endmodule

// File: rtl/tristate_pfd.sv
module tristate_pfd
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic fb_in,
  output logic drv_en,
  output logic drv_level,
  output logic locked
);
  logic       ref_rise;
  logic       fb_rise;
  pfd_state_t state;

  pfd_sync_edge #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk(clk), .rst(rst), .din(ref_in), .rise(ref_rise)
  );

  pfd_sync_edge #(.STAGES(SYNC_STAGES)) u_fb_sync (
    .clk(clk), .rst(rst), .din(fb_in), .rise(fb_rise)
  );

  pfd_core u_core (
    .clk(clk), .rst(rst), .ref_rise(ref_rise), .fb_rise(fb_rise), .state(state)
  );

  pfd_drive_decode u_dec (
    .state(state), .drv_en(drv_en), .drv_level(drv_level), .locked(locked)
  );

  AST_LOCK_MATCHES_RELEASE: assert property (@(posedge clk) disable iff (rst)
    locked != drv_en); // R8
  AST_LEVEL_LOW_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !drv_en |-> !drv_level); // R8
endmodule

// File: tb/tb_tristate_pfd.sv
module tb_tristate_pfd;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic drv_en, drv_level, locked;

  tristate_pfd dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .drv_en(drv_en), .drv_level(drv_level), .locked(locked)
  );

  typedef struct {
    logic  en;
    logic  lvl;
    logic  lk;
    string tag;
  } exp_t;

  exp_t  q[$];
  int    compared = 0;
  int    mismatched = 0;
  bit    started = 0;
  bit    done = 0;
  string cur_tag = "R1";
  logic [3:0] rh = '0;
  logic [3:0] fh = '0;
  int    mst = 0;  // 0 released, 1 high, 2 low

  // Driver: applies one cycle of input and pushes the expected outputs
  // seen just after the next rising clock edge (R2: third sampling edge).
  task automatic step(input logic r, input logic f);
    logic re, fe;
    exp_t e;
    @(negedge clk);
    ref_in = r;
    fb_in  = f;
    rh = {rh[2:0], r};
    fh = {fh[2:0], f};
    re = rh[2] & ~rh[3];
    fe = fh[2] & ~fh[3];
    if (re && fe)   mst = 0;
    else if (re)    mst = (mst == 2) ? 0 : 1;
    else if (fe)    mst = (mst == 1) ? 0 : 2;
    e.en  = (mst != 0);
    e.lvl = (mst == 1);
    e.lk  = (mst == 0);
    e.tag = cur_tag;
    started = 1;
    q.push_back(e);
  endtask

  // Square waves: period p, high times hr/hf, rising offsets orr/off.
  task automatic wave(input int p, input int hr, input int hf,
                      input int orr, input int off, input int periods);
    for (int t = 0; t < p * periods; t++)
      step(((t + p - orr) % p) < hr, ((t + p - off) % p) < hf);
  endtask

  task automatic check_now(input string tag, input logic en, input logic lvl, input logic lk);
    compared++;
    if (drv_en !== en || drv_level !== lvl || locked !== lk) begin
      mismatched++;
      $display("FAIL %s: en/lvl/lk got %b%b%b expected %b%b%b",
               tag, drv_en, drv_level, locked, en, lvl, lk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0;
    @(posedge clk); #1;
    check_now("R1", 1'b0, 1'b0, 1'b1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    rh = '0; fh = '0; mst = 0;
  endtask

  // Monitor: pops expectations and compares them after each rising edge.
  initial begin
    wait (started);
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        compared++;
        if (drv_en !== e.en || drv_level !== e.lvl) begin
          mismatched++;
          $display("FAIL %s: en/lvl got %b%b expected %b%b",
                   e.tag, drv_en, drv_level, e.en, e.lvl);
        end
        if (locked !== e.lk) begin
          mismatched++;
          $display("FAIL R8 (%s): locked got %b expected %b", e.tag, locked, e.lk);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    check_now("R1", 1'b0, 1'b0, 1'b1);
    @(negedge clk); rst = 1'b0;

    // R2: lone pulses, reference then feedback
    cur_tag = "R2";
    step(1, 0); for (int i = 0; i < 6; i++) step(0, 0);
    step(0, 1); for (int i = 0; i < 6; i++) step(0, 0);
    step(0, 1); for (int i = 0; i < 6; i++) step(1, 0);

    do_reset();
    cur_tag = "R3";                 // reference leads by 5
    wave(16, 8, 8, 0, 5, 4);

    do_reset();
    cur_tag = "R4";                 // feedback leads by 6
    wave(16, 8, 8, 6, 0, 4);

    do_reset();
    cur_tag = "R7";                 // in phase
    wave(12, 6, 6, 0, 0, 4);
    cur_tag = "R7";                 // both edges while driving high
    step(1, 0); step(0, 0); step(0, 0); step(0, 0); step(1, 1);
    for (int i = 0; i < 6; i++) step(0, 0);

    do_reset();
    cur_tag = "R9";                 // same phases as R3, other duty cycles
    wave(16, 2, 13, 0, 5, 4);
    cur_tag = "R9";
    wave(16, 11, 3, 0, 5, 3);

    do_reset();
    cur_tag = "R6";                 // no reference at all
    wave(10, 0, 5, 0, 3, 5);

    do_reset();
    cur_tag = "R5";                 // spurious reference pulse in low time
    for (int t = 0; t < 64; t++)
      step((t % 16 < 4) || (t % 16 == 12), ((t + 6) % 16) < 8);
    for (int i = 0; i < 4; i++) step(0, 0);

    @(posedge clk); #2;
    if (q.size() != 0) begin
      mismatched++;
      $display("FAIL R2: %0d expectations left unchecked", q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule